// File: doc/BRIEF.md
# Frame Receive Sample Extractor

This block sits on the host side of a serial codec link, after the frame parser. Each parsed incoming frame arrives as a one-cycle strobe carrying a 16-bit sample field and a data-valid bit. The block decides whether the sample is fresh. If it is, the sample is pushed into a 12-entry, 16-bit receive FIFO that software or a DMA engine drains through a show-ahead read port.

Two capture policies are available. In valid-bit mode the frame's own data-valid bit selects the frames that are stored. In counter mode the valid bit is ignored. The first frame after the channel is enabled is always stored, and after that a local down-counter, loaded from a programmable modulus, picks every (modulus+1)-th frame. A channel enable status bit gates all capture. Dropping the enable clears the counter, so the next enable starts again with a first-sample capture. Samples are left-justified, and the bits below the channel's significant width are cleared on the way in.

A push into a full FIFO is dropped. The drop raises a sticky overflow flag, which a one-cycle write-one pulse clears.

Top module: `rx_sample_extractor`

## Requirements
- R1: After synchronous reset, `empty` is 1 and `overflow` is 0.
- R2: With `cap_mode`=0 (valid-bit mode) and `chan_en`=1, a frame strobe (`frm_stb`=1) pushes its sample exactly when `frm_dv`=1.
- R3: While `chan_en`=0 no frame is captured in either mode. Dropping `chan_en` also re-arms the counter-mode first-sample capture.
- R4: With `cap_mode`=1 (counter mode) `frm_dv` is ignored. The first frame after enable is captured, and after it every (`rate_mod`+1)-th frame is captured, so `rate_mod`=0 captures every frame.
- R5: The FIFO returns samples in arrival order. `rd_data` shows the oldest entry whenever `empty`=0, and `rd_pop`=1 removes it.
- R6: The FIFO holds 12 entries. A push while 12 entries are held is discarded and leaves the stored entries unchanged.
- R7: A discarded push sets `overflow`, which stays set until a cycle with `ovf_clr`=1. If a drop and a clear fall in the same cycle, the flag stays set.
- R8: The stored word equals the frame sample with its low 16-`SAMPLE_BITS` bits forced to zero. `SAMPLE_BITS` defaults to 12, a mask of 16'hFFF0.
- R9: A sample captured on the clock edge that samples `frm_stb` appears on `rd_data`, with `empty`=0, right after that same edge when the FIFO was empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_stb | input | 1 | One-cycle strobe: a parsed frame is present |
| frm_sample | input | 16 | Sample field of the frame |
| frm_dv | input | 1 | Data-valid bit of the frame |
| chan_en | input | 1 | Channel enable status bit |
| cap_mode | input | 1 | 0 = valid-bit mode, 1 = counter mode |
| rate_mod | input | RATE_W | Modulus of the sample-rate counter |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |
| rd_pop | input | 1 | Remove the oldest FIFO entry |
| rd_data | output | 16 | Oldest FIFO entry (show-ahead) |
| empty | output | 1 | FIFO holds no entries |
| overflow | output | 1 | Sticky flag: a sample was dropped |

## Verification
The capture decision is combinational, and only the FIFO write is registered. A sample strobed before a rising edge is therefore at the head of an empty FIFO right after that edge. A pop requested at one falling edge exposes the next entry after the following rising edge. The overflow flag changes on the same edge as the dropped push. The bench drives inputs and samples outputs only on falling edges, so every comparison falls half a cycle after the edge that produced the value. The monitor pops only the entry it has just compared, and the model queue predicts which frames are stored.

// File: rtl/rxse_pkg.sv
package rxse_pkg;

    localparam int SAMPLE_W = 16;

    typedef enum logic {
        CAP_BY_VALID = 1'b0,
        CAP_BY_COUNT = 1'b1
    } cap_mode_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] sample;
        logic                dv;
    } frame_t;

    // Clear the bits below the significant width of a left-justified sample.
    function automatic logic [SAMPLE_W-1:0] justify(input logic [SAMPLE_W-1:0] s,
                                                    input int unsigned sig_bits);
        logic [SAMPLE_W-1:0] mask;
        for (int i = 0; i < SAMPLE_W; i++) begin
            mask[i] = (i >= SAMPLE_W - int'(sig_bits));
        end
        return s & mask;
    endfunction

endpackage

// File: rtl/rxse_capture_ctrl.sv
module rxse_capture_ctrl
    import rxse_pkg::*;
#(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_stb,
    input  logic              frm_dv,
    input  logic              chan_en,
    input  cap_mode_e         mode,
    input  logic [RATE_W-1:0] rate_mod,
    output logic              capture
);

    logic [RATE_W-1:0] cnt_q;
    logic              first_q;
    logic              count_hit;

    assign count_hit = first_q || (cnt_q == '0);

    always_comb begin
        capture = 1'b0;
        if (chan_en && frm_stb) begin
            if (mode == CAP_BY_VALID) capture = frm_dv;
            else                      capture = count_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !chan_en) begin
            cnt_q   <= '0;
            first_q <= 1'b1;
        end else if (frm_stb && mode == CAP_BY_COUNT) begin
            first_q <= 1'b0;
            if (count_hit) cnt_q <= rate_mod;
            else           cnt_q <= cnt_q - 1'b1;
        end
    end

    // R4: between reloads, counter mode does not capture
    a_r4_no_capture_mid_count: assert property (@(posedge clk) disable iff (rst)
        (chan_en && frm_stb && mode == CAP_BY_COUNT && !first_q && cnt_q != '0) |-> !capture);

    // R3: a disabled channel leaves the first-sample capture armed
    a_r3_rearm_on_disable: assert property (@(posedge clk) disable iff (rst)
        !chan_en |=> first_q);

endmodule

// File: rtl/rxse_fifo.sv
module rxse_fifo #(
    parameter int DEPTH = 12,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         dropped
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             full, do_wr, do_rd;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign do_wr   = push && !full;
    assign do_rd   = pop && !empty;
    assign dropped = push && full;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R6: occupancy never exceeds the depth
    a_r6_bounded_count: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);

    // R6: a push while full leaves occupancy unchanged
    a_r6_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> $stable(count));

    // R5: popping the last entry empties the FIFO
    a_r5_last_pop_empties: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_W'(1) && pop && !push) |=> empty);

endmodule

// File: rtl/rx_sample_extractor.sv
module rx_sample_extractor
    import rxse_pkg::*;
#(
    parameter int RATE_W      = 8,
    parameter int FIFO_DEPTH  = 12,
    parameter int SAMPLE_BITS = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_stb,
    input  logic [15:0]       frm_sample,
    input  logic              frm_dv,
    input  logic              chan_en,
    input  logic              cap_mode,
    input  logic [RATE_W-1:0] rate_mod,
    input  logic              ovf_clr,
    input  logic              rd_pop,
    output logic [15:0]       rd_data,
    output logic              empty,
    output logic              overflow
);

    frame_t              frm;
    cap_mode_e           mode;
    logic                capture;
    logic                dropped;
    logic [SAMPLE_W-1:0] stored_word;

    assign frm.sample  = frm_sample;
    assign frm.dv      = frm_dv;
    assign mode        = cap_mode_e'(cap_mode);
    assign stored_word = justify(frm.sample, SAMPLE_BITS);

    rxse_capture_ctrl #(
        .RATE_W (RATE_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .frm_stb  (frm_stb),
        .frm_dv   (frm.dv),
        .chan_en  (chan_en),
        .mode     (mode),
        .rate_mod (rate_mod),
        .capture  (capture)
    );

    rxse_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (SAMPLE_W)
    ) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (capture),
        .wdata   (stored_word),
        .pop     (rd_pop),
        .rdata   (rd_data),
        .empty   (empty),
        .dropped (dropped)
    );

    always_ff @(posedge clk) begin
        if (rst)           overflow <= 1'b0;
        else if (dropped)  overflow <= 1'b1;
        else if (ovf_clr)  overflow <= 1'b0;
    end

    // R3: nothing is captured while the channel is disabled
    a_r3_no_capture_disabled: assert property (@(posedge clk) disable iff (rst)
        !chan_en |-> !capture);

    // R2: in valid-bit mode a frame with a clear valid bit is not captured
    a_r2_valid_gates: assert property (@(posedge clk) disable iff (rst)
        (frm_stb && !cap_mode && !frm_dv) |-> !capture);

    // R7: overflow holds without a clear
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (overflow && !ovf_clr) |=> overflow);

    // R7: overflow rises only after a dropped push
    a_r7_ovf_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(dropped));

endmodule

// File: tb/rx_sample_extractor_tb.sv
module rx_sample_extractor_tb;

    localparam int DEPTH = 12;

    logic        clk = 1'b0;
    logic        rst;
    logic        frm_stb, frm_dv, chan_en, cap_mode, ovf_clr, rd_pop;
    logic [15:0] frm_sample;
    logic [7:0]  rate_mod;
    logic [15:0] rd_data;
    logic        empty, overflow;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit drain = 1'b0;

    logic [15:0] expq[$];
    bit          m_first = 1'b1;
    int          m_cnt   = 0;

    always #2 clk = ~clk;

    rx_sample_extractor u_dut (
        .clk(clk), .rst(rst), .frm_stb(frm_stb), .frm_sample(frm_sample),
        .frm_dv(frm_dv), .chan_en(chan_en), .cap_mode(cap_mode),
        .rate_mod(rate_mod), .ovf_clr(ovf_clr), .rd_pop(rd_pop),
        .rd_data(rd_data), .empty(empty), .overflow(overflow)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Driver: one frame strobe plus a gap cycle; predicts the stored word.
    task automatic send_frame(input logic [15:0] s, input logic dv);
        bit cap;
        @(negedge clk);
        frm_stb = 1'b1; frm_sample = s; frm_dv = dv;
        if (!chan_en) begin
            cap = 1'b0; m_first = 1'b1; m_cnt = 0;
        end else if (!cap_mode) begin
            cap = dv;
        end else begin
            cap = m_first || (m_cnt == 0);
            if (cap) m_cnt = int'(rate_mod); else m_cnt--;
            m_first = 1'b0;
        end
        // R6: model drops pushes into a full FIFO (only tracked while not draining)
        if (cap && (drain || expq.size() < DEPTH)) expq.push_back(s & 16'hFFF0);
        @(negedge clk);
        frm_stb = 1'b0;
    endtask

    task automatic set_enable(input logic en);
        @(negedge clk);
        chan_en = en;
        if (!en) begin m_first = 1'b1; m_cnt = 0; end
    endtask

    task automatic wait_drained();
        int n = 0;
        while ((expq.size() != 0 || !empty) && n < 200) begin
            @(negedge clk); n++;
        end
        check(empty && expq.size() == 0, "R5 drained", int'(empty), 1);
    endtask

    // Monitor: compare head with the model queue, then pop it.
    always @(negedge clk) begin
        rd_pop = 1'b0;
        if (drain && !rst && !empty) begin
            if (expq.size() == 0) begin
                check(1'b0, "R2/R4 unexpected sample", int'(rd_data), 0);
            end else begin
                logic [15:0] e;
                e = expq.pop_front();
                check(rd_data == e, "R5/R8 sample", int'(rd_data), int'(e));
            end
            rd_pop = 1'b1;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; frm_stb = 1'b0; frm_sample = '0; frm_dv = 1'b0;
        chan_en = 1'b0; cap_mode = 1'b0; rate_mod = 8'd0; ovf_clr = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(empty == 1'b1, "R1 empty", int'(empty), 1);
        check(overflow == 1'b0, "R1 overflow", int'(overflow), 0);
        rst = 1'b0;

        // R9: latency of one edge, checked with draining off
        set_enable(1'b1);
        @(negedge clk);
        frm_stb = 1'b1; frm_sample = 16'hABCD; frm_dv = 1'b1;
        @(negedge clk);
        frm_stb = 1'b0;
        check(!empty && rd_data == 16'hABC0, "R9 R8 visible after one edge", int'(rd_data), 16'hABC0);
        expq.push_back(16'hABC0);
        drain = 1'b1;
        wait_drained();

        // R2: valid-bit mode, mixed valid bits
        for (int i = 0; i < 10; i++) send_frame(16'h1000 + 16'(i * 16'h0111), i[0] ^ i[1]);
        wait_drained();

        // R3: disabled channel ignores valid frames (both modes)
        set_enable(1'b0);
        for (int i = 0; i < 4; i++) send_frame(16'hDEAD, 1'b1);
        cap_mode = 1'b1;
        for (int i = 0; i < 4; i++) send_frame(16'hBEEF, 1'b1);
        repeat (3) @(negedge clk);
        check(empty == 1'b1, "R3 nothing captured while disabled", int'(empty), 1);

        // R4: counter mode, modulus 2, valid bit held low
        rate_mod = 8'd2;
        set_enable(1'b1);
        for (int i = 0; i < 10; i++) send_frame(16'h2000 + 16'(i * 16'h0010), 1'b0);
        wait_drained();
        // R3: re-enable restarts with a first-sample capture
        set_enable(1'b0);
        set_enable(1'b1);
        for (int i = 0; i < 5; i++) send_frame(16'h3000 + 16'(i * 16'h0020), 1'b0);
        wait_drained();
        // R4: modulus 0 captures every frame
        rate_mod = 8'd0;
        set_enable(1'b0);
        set_enable(1'b1);
        for (int i = 0; i < 6; i++) send_frame(16'h4000 + 16'(i * 16'h0101), 1'b0);
        wait_drained();

        // R6/R7: fill past the depth with draining off
        cap_mode = 1'b0;
        drain = 1'b0;
        for (int i = 0; i < DEPTH + 2; i++) send_frame(16'h5000 + 16'(i * 16'h0100), 1'b1);
        @(negedge clk);
        check(overflow == 1'b1, "R7 overflow set on drop", int'(overflow), 1);
        repeat (4) @(negedge clk);
        check(overflow == 1'b1, "R7 overflow sticky", int'(overflow), 1);
        drain = 1'b1;
        wait_drained();
        check(overflow == 1'b1, "R7 overflow survives drain", int'(overflow), 1);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        check(overflow == 1'b0, "R7 overflow cleared", int'(overflow), 0);

        finish_run();
    end

endmodule